// File: doc/BRIEF.md
# Configurable Synchronous Serial Port

The block exchanges one byte at a time with an external device over three lines: a shift clock, a data output and a data input. A mode register picks the shift clock source (an internal divided clock, an external clock pin, or pulses from a timer), the bit order (most- or least-significant bit first) and whether the port transmits while it receives or only receives. In receive-only mode the data output stays high for the whole transfer.

Software loads a byte into the buffer while the port is idle, and that write starts the transfer. Each falling shift-clock edge puts the next outgoing bit on the data output. Each rising edge shifts the data input into the same buffer and advances a bit counter. On the eighth rising edge the port sets an interrupt request, clears busy and parks the shift clock high until the next start. When the clock source is the external pin, the port stops driving the pin. It synchronises the pin into the system clock domain and runs the transfer on the pin's detected edges.

Top module: `ser_port`

## Requirements
- R1: After reset, `sck_o` and `sdo_o` are 1, `sck_oe_o` is 1, `busy_o` and `irq_o` are 0, and `buf_rdata_o` is 0.
- R2: A buffer write while idle starts a transfer and raises `busy_o` on the next cycle. On the eighth rising shift-clock edge `busy_o` falls and `irq_o` is set in the same cycle.
- R3: Mode bit 4 = 0 sends and receives bit 7 first; bit 4 = 1 sends and receives bit 0 first. Data output changes on falling shift-clock edges and data input is sampled on rising edges. After completion `buf_rdata_o` equals the received byte.
- R4: Mode bit 5 = 1 (receive-only) holds `sdo_o` at 1 for the whole transfer, while reception proceeds normally.
- R5: Mode bits 1:0 = 00 or 11 select the internal clock. `sck_oe_o` = 1 and every shift-clock phase lasts 2^(d+1) system cycles, where d is mode bits 3:2.
- R6: Mode bits 1:0 = 10 select the timer source. The shift clock toggles once per `tmr_tick_i` pulse and `sck_oe_o` = 1.
- R7: Mode bits 1:0 = 01 select the external pin. `sck_oe_o` = 0, and the transfer runs on the synchronised edges of `sck_i`.
- R8: A buffer write while busy is ignored and does not change the transmitted data.
- R9: While idle, `sck_o` stays 1.
- R10: `irq_o` stays set until `irq_clr_i` is pulsed, then reads 0.
- R11: A mode write while busy is ignored. Rate, order and receive-only setting hold for the whole transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_wr_i | input | 1 | Mode register write strobe |
| mode_i | input | 6 | Mode value: [1:0] clock source, [3:2] divider, [4] LSB first, [5] receive-only |
| buf_wr_i | input | 1 | Buffer write strobe; starts a transfer when idle |
| buf_wdata_i | input | DATA_W | Byte to transmit |
| buf_rdata_o | output | DATA_W | Buffer contents (received byte after completion) |
| busy_o | output | 1 | Transfer in progress |
| irq_o | output | 1 | Transfer-complete request |
| irq_clr_i | input | 1 | Clears the request |
| tmr_tick_i | input | 1 | Timer pulse, one per shift-clock phase in timer mode |
| sck_i | input | 1 | Shift clock pin, input side |
| sck_o | output | 1 | Shift clock pin, output side |
| sck_oe_o | output | 1 | Shift clock pin output enable |
| sdo_o | output | 1 | Serial data output |
| sdi_i | input | 1 | Serial data input |

## Verification
The assertions check these properties on every cycle:
- the shift clock rests high whenever the port is idle;
- the data output stays high during a receive-only transfer;
- the clock pin is released in external mode;
- the mode is frozen while busy;
- a start raises busy;
- the end of busy always comes with the request.

The data itself cannot be judged cycle by cycle, so the bench's peer model covers it. The peer exchanges bytes under every clock source, bit order and direction mode. The bench then checks:
- the bytes exchanged in both directions;
- the measured shift-clock phase lengths;
- that writes made while busy have no effect.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int DIV_W = 2;

  typedef enum logic [1:0] {
    CS_INT = 2'd0,
    CS_EXT = 2'd1,
    CS_TMR = 2'd2,
    CS_ALT = 2'd3
  } clk_src_e;

  typedef struct packed {
    logic             rx_only;
    logic             lsb_first;
    logic [DIV_W-1:0] div_sel;
    clk_src_e         clk_sel;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);
endpackage

// File: rtl/ser_clk_gen.sv
module ser_clk_gen
  import ser_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  clk_src_e         clk_sel_i,
  input  logic [DIV_W-1:0] div_sel_i,
  input  logic             tmr_tick_i,
  input  logic             sck_i,
  output logic             sck_o,
  output logic             sck_oe_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam int PRESC_W = (1 << DIV_W) + 1;

  logic [SYNC_STAGES:0]  sync_q;
  logic [PRESC_W-1:0]    presc_q;
  logic [PRESC_W-1:0]    limit;
  logic                  sck_q;
  logic                  int_src, ext_src;
  logic                  toggle;
  logic                  ext_rise, ext_fall;

  assign int_src = (clk_sel_i == CS_INT) || (clk_sel_i == CS_ALT);
  assign ext_src = (clk_sel_i == CS_EXT);
  assign limit   = (PRESC_W'(2) << div_sel_i) - PRESC_W'(1);

  // pin synchroniser, last stage kept for edge detection
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], sck_i};
  end

  assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign ext_fall = ~sync_q[SYNC_STAGES-1] & sync_q[SYNC_STAGES];

  always_comb begin
    toggle = 1'b0;
    if (run_i) begin
      if (clk_sel_i == CS_TMR) toggle = tmr_tick_i;
      else if (int_src)        toggle = (presc_q == limit);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           presc_q <= '0;
    else if (!run_i || !int_src || toggle) presc_q <= '0;
    else                                   presc_q <= presc_q + PRESC_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sck_q <= 1'b1;
    else if (toggle) sck_q <= ~sck_q;
    else if (!run_i) sck_q <= 1'b1;
  end

  assign rise_o   = ext_src ? (run_i & ext_rise) : (toggle & ~sck_q);
  assign fall_o   = ext_src ? (run_i & ext_fall) : (toggle & sck_q);
  assign sck_o    = sck_q;
  assign sck_oe_o = ~ext_src;
endmodule

// File: rtl/ser_shift.sv
module ser_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              lsb_first_i,
  input  logic              rx_only_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sdi_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sdo_o,
  output logic              done_o
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              sdo_q;

  assign done_o = rise_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
      sdo_q <= 1'b1;
    end else if (load_i) begin
      sr_q  <= wdata_i;
      cnt_q <= '0;
      sdo_q <= 1'b1;
    end else begin
      if (fall_i && !rx_only_i)
        sdo_q <= lsb_first_i ? sr_q[0] : sr_q[DATA_W-1];
      if (rise_i) begin
        sr_q  <= lsb_first_i ? {sdi_i, sr_q[DATA_W-1:1]} : {sr_q[DATA_W-2:0], sdi_i};
        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
      end
    end
  end

  assign data_o = sr_q;
  assign sdo_o  = sdo_q;
endmodule

// File: rtl/ser_port.sv
module ser_port
  import ser_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_wr_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              buf_wr_i,
  input  logic [DATA_W-1:0] buf_wdata_i,
  output logic [DATA_W-1:0] buf_rdata_o,
  output logic              busy_o,
  output logic              irq_o,
  input  logic              irq_clr_i,
  input  logic              tmr_tick_i,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  output logic              sdo_o,
  input  logic              sdi_i
);
  mode_t mode_q;
  logic  busy_q, irq_q;
  logic  load, done, rise, fall;

  assign load = buf_wr_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   mode_q <= '0;
    else if (mode_wr_i && !busy_q) mode_q <= mode_t'(mode_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   busy_q <= 1'b0;
    else if (load) busy_q <= 1'b1;
    else if (done) busy_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (done)      irq_q <= 1'b1;
    else if (irq_clr_i) irq_q <= 1'b0;
  end

  ser_clk_gen #(.SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (busy_q),
    .clk_sel_i (mode_q.clk_sel),
    .div_sel_i (mode_q.div_sel),
    .tmr_tick_i(tmr_tick_i),
    .sck_i     (sck_i),
    .sck_o     (sck_o),
    .sck_oe_o  (sck_oe_o),
    .rise_o    (rise),
    .fall_o    (fall)
  );

  ser_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .wdata_i    (buf_wdata_i),
    .lsb_first_i(mode_q.lsb_first),
    .rx_only_i  (mode_q.rx_only),
    .rise_i     (rise),
    .fall_i     (fall),
    .sdi_i      (sdi_i),
    .data_o     (buf_rdata_o),
    .sdo_o      (sdo_o),
    .done_o     (done)
  );

  assign busy_o = busy_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/ser_port_chk.sv
module ser_port_chk
  import ser_pkg::*;
(
  input logic  clk_i,
  input logic  rst_ni,
  input logic  buf_wr_i,
  input logic  busy_o,
  input logic  irq_o,
  input logic  sck_o,
  input logic  sck_oe_o,
  input logic  sdo_o,
  input mode_t mode_q
);
  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_wr_i && !busy_o) |=> busy_o);

  p_done_irq_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> irq_o);

  p_rx_only_sdo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mode_q.rx_only) |-> sdo_o);

  p_ext_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.clk_sel == CS_EXT) |-> !sck_oe_o);

  p_idle_sck_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> sck_o);

  p_mode_locked_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(mode_q));
endmodule

bind ser_port ser_port_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .buf_wr_i(buf_wr_i),
  .busy_o  (busy_o),
  .irq_o   (irq_o),
  .sck_o   (sck_o),
  .sck_oe_o(sck_oe_o),
  .sdo_o   (sdo_o),
  .mode_q  (mode_q)
);

// File: tb/tb_ser_port.sv
`timescale 1ns/1ps
module tb_ser_port;
  import ser_pkg::*;
  localparam int DATA_W   = 8;
  localparam int TP       = 6;
  localparam int EXT_HALF = 10;

  logic              clk = 1'b0, rst_n = 1'b0;
  logic              mode_wr = 1'b0, buf_wr = 1'b0, irq_clr = 1'b0;
  logic [MODE_W-1:0] mode_d = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              busy, irq, tmr_tick = 1'b0, sck_ext = 1'b1;
  logic              sck_o, sck_oe, sdo, sdi = 1'b1;

  ser_port #(.DATA_W(DATA_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_wr_i(mode_wr), .mode_i(mode_d),
    .buf_wr_i(buf_wr), .buf_wdata_i(wdata), .buf_rdata_o(rdata),
    .busy_o(busy), .irq_o(irq), .irq_clr_i(irq_clr), .tmr_tick_i(tmr_tick),
    .sck_i(sck_ext), .sck_o(sck_o), .sck_oe_o(sck_oe), .sdo_o(sdo), .sdi_i(sdi)
  );

  always #2.5 clk = ~clk;

  int  n_chk = 0, n_fail = 0;
  bit  finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // free-running timer pulses
  int tcnt = 0;
  always @(negedge clk) begin
    if (tcnt == TP - 1) begin tcnt <= 0; tmr_tick <= 1'b1; end
    else begin tcnt <= tcnt + 1; tmr_tick <= 1'b0; end
  end

  // peer model
  wire               sck_line = sck_oe ? sck_o : sck_ext;
  bit                peer_on = 0, peer_lsb = 0, sdo_low = 0;
  logic [DATA_W-1:0] peer_tx = '0, peer_rx = '0;
  int                ptx = 0, prx = 0;

  always @(negedge sck_line) if (peer_on && ptx < DATA_W) begin
    sdi <= peer_lsb ? peer_tx[ptx] : peer_tx[DATA_W-1-ptx];
    ptx++;
  end

  always @(posedge sck_line) if (peer_on && prx < DATA_W) begin
    if (peer_lsb) peer_rx[prx] = sdo;
    else          peer_rx[DATA_W-1-prx] = sdo;
    prx++;
  end

  always @(negedge clk) if (peer_on && busy && !sdo) sdo_low <= 1'b1;

  // shift clock low-phase measurement
  int low_cnt = 0, lo_min = 0, lo_max = 0;
  always @(negedge clk) begin
    if (!sck_o) low_cnt <= low_cnt + 1;
    else if (low_cnt != 0) begin
      if (peer_on) begin
        if (low_cnt < lo_min) lo_min <= low_cnt;
        if (low_cnt > lo_max) lo_max <= low_cnt;
      end
      low_cnt <= 0;
    end
  end

  task automatic xfer(input logic [1:0] cs, input int div, input bit lsb, input bit rxo,
                      input logic [DATA_W-1:0] tx, input logic [DATA_W-1:0] pb);
    logic [MODE_W-1:0] m;
    int                w;
    int                half;
    bit                hi_ok;
    m = {rxo, lsb, 2'(div), cs};
    @(negedge clk); mode_wr = 1'b1; mode_d = m;
    @(negedge clk); mode_wr = 1'b0;
    chk(sck_oe == (cs != 2'b01), (cs == 2'b01) ? "R7 oe" : "R5 oe", sck_oe, cs != 2'b01);
    peer_tx = pb; peer_lsb = lsb; ptx = 0; prx = 0; peer_rx = '0;
    sdo_low = 0; lo_min = 9999; lo_max = 0; peer_on = 1;
    buf_wr = 1'b1; wdata = tx;
    @(negedge clk);
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    // ignored writes while busy (R8, R11)
    wdata = ~tx; mode_wr = 1'b1; mode_d = ~m;
    @(negedge clk); buf_wr = 1'b0; mode_wr = 1'b0;
    if (cs == 2'b01) begin
      for (int b = 0; b < DATA_W; b++) begin
        sck_ext = 1'b0; repeat (EXT_HALF) @(negedge clk);
        sck_ext = 1'b1; repeat (EXT_HALF) @(negedge clk);
      end
    end
    w = 0;
    while (busy && w < 5000) begin @(negedge clk); w++; end
    chk(!busy, "R2 busy cleared", busy, 0);
    chk(irq == 1'b1, "R2 irq set", irq, 1);
    chk(prx == DATA_W, "R3 peer bit count", prx, DATA_W);
    chk(rdata == pb, "R3 received byte", rdata, pb);
    chk(peer_rx == (rxo ? '1 : tx), rxo ? "R4 sdo high" : "R8 R3 transmitted byte",
        peer_rx, rxo ? 8'hFF : tx);
    if (rxo) chk(!sdo_low, "R4 sdo low seen", sdo_low, 0);
    if (cs != 2'b01) begin
      half = (cs == 2'b10) ? TP : (2 << div);
      chk(lo_min == half && lo_max == half, (cs == 2'b10) ? "R6 phase" : "R5 R11 phase",
          lo_max, half);
    end
    peer_on = 0;
    hi_ok = 1;
    repeat (30) begin @(negedge clk); if (!sck_o) hi_ok = 0; end
    chk(hi_ok, "R9 idle sck high", hi_ok, 1);
    chk(irq == 1'b1, "R10 irq held", irq, 1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    chk(irq == 1'b0, "R10 irq cleared", irq, 0);
  endtask

  initial begin
    logic [DATA_W-1:0] pats [3];
    pats[0] = 8'hA5; pats[1] = 8'h01; pats[2] = 8'hC3;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sck_o && sdo && sck_oe && !busy && !irq && rdata == '0, "R1 reset state",
        {sck_o, sdo, sck_oe, busy, irq}, 5'b11100);
    for (int cs = 0; cs < 4; cs++) begin
      for (int div = 0; div < 4; div++) begin
        if (cs != 0 && div != 0) continue;
        for (int lsb = 0; lsb < 2; lsb++)
          for (int rxo = 0; rxo < 2; rxo++)
            for (int p = 0; p < 3; p++)
              xfer(2'(cs), div, lsb[0], rxo[0], pats[p], pats[p] ^ 8'h96);
      end
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule